// File: doc/BRIEF.md
# Grouped Interrupt Event Controller

This block collects single-cycle event pulses from an Ethernet MAC datapath into a 32-bit event register that software can read at any time. Software clears bits by writing ones, and a separate enable register selects which events may raise a hardware interrupt. The enabled events are sorted into three interrupt lines: one for transmit, one for receive, and one for errors and diagnostics.

The transmit and receive lines can be held back by a frame-count coalescer, one for each direction. Each coalescer counts frame-complete events. It releases its line when a programmed number of frames has been seen, or when a programmed number of cycles has passed since the first frame it counted, whichever comes first. Software reaches the event, enable, threshold and timeout registers through a simple register bus with a write strobe and a combinational read port.

Event bit layout:
- Bit 0: transmit buffer.
- Bit 1: transmit frame.
- Bit 2: receive buffer.
- Bit 3: receive frame.
- Bits 4 to 20: seventeen error and diagnostic events.
- Bits 21 to 31: unused.

Word addresses:
- 0: event register.
- 1: enable register.
- 2: transmit threshold, bits 7:0.
- 3: transmit timeout, bits 15:0.
- 4: receive threshold, bits 7:0.
- 5: receive timeout, bits 15:0.
- 6 and 7: read as 0, and writes to them are ignored.

Top module: `irq_event_group`

## Requirements
- R1: A high `evtPulse[i]` sets event bit i at the next clock edge, and a read of address 0 returns the event register in the same cycle as the read.
- R2: A write to address 0 clears every event bit whose write-data bit is 1, and it leaves bits whose write-data bit is 0 unchanged.
- R3: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R4: Bits 21 to 31 of the event and enable registers always read 0, and writes to those bits are ignored.
- R5: An event bit whose enable bit (address 1, same bit position) is 0 never raises any interrupt line.
- R6: `irqTx` is high when bit 0 or bit 1 is set and enabled and the transmit gate is open; it stays high until both bits are cleared.
- R7: `irqRx` is high when bit 2 or bit 3 is set and enabled and the receive gate is open; it stays high until both bits are cleared.
- R8: `irqErr` is high when any enabled bit in 4 to 20 is set, and it goes low only when none of them is set.
- R9: With a threshold N of 2 or more, the gate opens on the Nth counted frame event (bit 1 for transmit, bit 3 for receive).
- R10: With a nonzero timeout T, the gate opens T cycles after the frame event that started the count, if the threshold has not been reached by then. A timeout of 0 disables the timer.
- R11: A threshold of 0 or 1 keeps the gate always open. When the gate opens, the frame counter and the timer both restart from zero.
- R12: Each interrupt line is a registered level that goes high two clock edges after the event pulse that causes it. All lines read 0 during synchronous reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from `busAddr` |
| evtPulse | input | 21 | Event pulses from the datapath, one per event bit |
| irqTx | output | 1 | Transmit interrupt level |
| irqRx | output | 1 | Receive interrupt level |
| irqErr | output | 1 | Error and diagnostic interrupt level |

## Verification
Directed patterns separate cases that would otherwise look alike:
- A pulse that lands together with a clear of the same bit shows that the pulse wins.
- A clear of only one of two set transmit bits shows that the line is held until both are clear.
- A masked error pulse shows the enable gate at work.
- A count-threshold release, followed by two further frames, shows that the counter restarts after a release.
- A lone frame with a timeout shows that the timer releases on the exact cycle.

After these, thousands of cycles of seeded random pulses and register writes, with small thresholds and timeouts, are compared every cycle against a cycle-level model. This mixes races between counting, timing out and software clearing that the directed cases do not reach.

// File: rtl/irq_event_group_pkg.sv
package irq_event_group_pkg;

  localparam int REG_W   = 32;
  localparam int NUM_EVT = 21;
  localparam int ADDR_W  = 3;
  localparam int NUM_DIR = 2;
  localparam int NUM_GRP = 3;

  localparam int BIT_TX_BUF = 0;
  localparam int BIT_TX_FRM = 1;
  localparam int BIT_RX_BUF = 2;
  localparam int BIT_RX_FRM = 3;
  localparam int BIT_ERR_LO = 4;
  localparam int BIT_ERR_HI = NUM_EVT - 1;

  localparam logic [ADDR_W-1:0] ADR_EVENT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_TX_THR = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TX_TMO = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RX_THR = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RX_TMO = 3'd5;

  function automatic logic [REG_W-1:0] bitRange(input int lo, input int hi);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i >= lo && i <= hi) v[i] = 1'b1;
    end
    return v;
  endfunction

  localparam logic [REG_W-1:0] IMPL_MASK = bitRange(0, NUM_EVT - 1);

  // group 0 = transmit, 1 = receive, 2 = error/diagnostic
  function automatic logic [REG_W-1:0] groupSel(input int g);
    case (g)
      0:       return bitRange(BIT_TX_BUF, BIT_TX_FRM);
      1:       return bitRange(BIT_RX_BUF, BIT_RX_FRM);
      default: return bitRange(BIT_ERR_LO, BIT_ERR_HI);
    endcase
  endfunction

  typedef struct packed {
    logic                 evtClr;
    logic                 enableWr;
    logic [NUM_DIR-1:0]   dirGate;
  } ievtStrobe_t;

endpackage

// File: rtl/irq_event_group_coalesce.sv
module irq_event_group_coalesce #(
  parameter int THR_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             framePulse,
  input  logic             pend,
  input  logic [THR_W-1:0] thresh,
  input  logic [TMO_W-1:0] timeout,
  output logic             gate
);

  logic [THR_W-1:0] frameCnt;
  logic [TMO_W-1:0] waitCnt;
  logic             held;
  logic             bypass;
  logic             hitCount;
  logic             hitTime;
  logic             release_;

  assign bypass   = (thresh <= THR_W'(1));
  assign hitCount = framePulse &&
                    (((THR_W+1)'(frameCnt) + (THR_W+1)'(1)) >= (THR_W+1)'(thresh));
  assign hitTime  = (frameCnt != '0) && (timeout != '0) &&
                    (((TMO_W+1)'(waitCnt) + (TMO_W+1)'(1)) >= (TMO_W+1)'(timeout));
  assign release_ = !bypass && (hitCount || hitTime);
  assign gate     = bypass || held;

  always_ff @(posedge clk) begin
    if (rst) begin
      frameCnt <= '0;
      waitCnt  <= '0;
      held     <= 1'b0;
    end else if (bypass) begin
      frameCnt <= '0;
      waitCnt  <= '0;
      held     <= 1'b0;
    end else if (release_) begin
      frameCnt <= '0;
      waitCnt  <= '0;
      held     <= 1'b1;
    end else begin
      if (framePulse) frameCnt <= frameCnt + THR_W'(1);
      waitCnt <= (frameCnt != '0) ? waitCnt + TMO_W'(1) : '0;
      if (!pend) held <= 1'b0;
    end
  end

  // R11: counter and timer restart whenever the gate opens
  a_r11_release_restarts: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> (frameCnt == '0 && waitCnt == '0));

  // R11: a bypassed coalescer keeps no count
  a_r11_bypass_idle: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (frameCnt == '0));

  // R10: the timer only runs while frames are being counted
  a_r10_timer_idle: assert property (@(posedge clk) disable iff (rst)
    (frameCnt == '0 && !framePulse) |=> (waitCnt == '0));

endmodule

// File: rtl/irq_event_group_ctrl.sv
module irq_event_group_ctrl
  import irq_event_group_pkg::*;
#(
  parameter int THR_W = 8,
  parameter int TMO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [TMO_W-1:0]   cfgWdata,
  input  logic [NUM_DIR-1:0] framePulse,
  input  logic [REG_W-1:0]   evtReg,
  input  logic [REG_W-1:0]   enableReg,
  output ievtStrobe_t        strobe,
  output logic [REG_W-1:0]   busRdata
);

  logic [THR_W-1:0] thrReg [NUM_DIR];
  logic [TMO_W-1:0] tmoReg [NUM_DIR];
  logic [NUM_DIR-1:0] gateVec;

  assign strobe.evtClr   = busWe && (busAddr == ADR_EVENT);
  assign strobe.enableWr = busWe && (busAddr == ADR_ENABLE);
  assign strobe.dirGate  = gateVec;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam logic [ADDR_W-1:0] THR_ADR = (d == 0) ? ADR_TX_THR : ADR_RX_THR;
    localparam logic [ADDR_W-1:0] TMO_ADR = (d == 0) ? ADR_TX_TMO : ADR_RX_TMO;

    always_ff @(posedge clk) begin
      if (rst) begin
        thrReg[d] <= '0;
        tmoReg[d] <= '0;
      end else if (busWe) begin
        if (busAddr == THR_ADR) thrReg[d] <= cfgWdata[THR_W-1:0];
        if (busAddr == TMO_ADR) tmoReg[d] <= cfgWdata;
      end
    end

    irq_event_group_coalesce #(
      .THR_W(THR_W),
      .TMO_W(TMO_W)
    ) i_coalesce (
      .clk       (clk),
      .rst       (rst),
      .framePulse(framePulse[d]),
      .pend      (|evtReg[2*d +: 2]),
      .thresh    (thrReg[d]),
      .timeout   (tmoReg[d]),
      .gate      (gateVec[d])
    );
  end

  always_comb begin
    case (busAddr)
      ADR_EVENT:  busRdata = evtReg;
      ADR_ENABLE: busRdata = enableReg;
      ADR_TX_THR: busRdata = REG_W'(thrReg[0]);
      ADR_TX_TMO: busRdata = REG_W'(tmoReg[0]);
      ADR_RX_THR: busRdata = REG_W'(thrReg[1]);
      ADR_RX_TMO: busRdata = REG_W'(tmoReg[1]);
      default:    busRdata = '0;
    endcase
  end

  // R11: a threshold of 0 or 1 leaves the direction gate open
  a_r11_low_thr_open: assert property (@(posedge clk) disable iff (rst)
    (thrReg[0] <= THR_W'(1)) |-> gateVec[0]);

endmodule

// File: rtl/irq_event_group_dp.sv
module irq_event_group_dp
  import irq_event_group_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ievtStrobe_t        strobe,
  input  logic [REG_W-1:0]   busWdata,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [REG_W-1:0]   evtReg,
  output logic [REG_W-1:0]   enableReg,
  output logic               irqTx,
  output logic               irqRx,
  output logic               irqErr
);

  logic [REG_W-1:0]   pulseVec;
  logic [REG_W-1:0]   clrVec;
  logic [REG_W-1:0]   evtNext;
  logic [NUM_GRP-1:0] irqVec;
  logic [NUM_GRP-1:0] grpGate;

  assign pulseVec = REG_W'(evtPulse);
  assign clrVec   = strobe.evtClr ? busWdata : '0;
  assign evtNext  = ((evtReg & ~clrVec) | pulseVec) & IMPL_MASK;
  assign grpGate  = {1'b1, strobe.dirGate};

  always_ff @(posedge clk) begin
    if (rst) begin
      evtReg    <= '0;
      enableReg <= '0;
    end else begin
      evtReg <= evtNext;
      if (strobe.enableWr) enableReg <= busWdata & IMPL_MASK;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [REG_W-1:0] SEL = groupSel(g);
    always_ff @(posedge clk) begin
      if (rst) irqVec[g] <= 1'b0;
      else     irqVec[g] <= (|(evtReg & enableReg & SEL)) && grpGate[g];
    end
  end

  assign irqTx  = irqVec[0];
  assign irqRx  = irqVec[1];
  assign irqErr = irqVec[2];

  // R1: every pulsed bit is set one edge later
  a_r1_pulse_sets: assert property (@(posedge clk) disable iff (rst)
    (|evtPulse) |=> ((evtReg & $past(pulseVec)) == $past(pulseVec)));

  // R2: a written one without a competing pulse clears the bit
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    strobe.evtClr |=> ((evtReg & $past(busWdata & ~pulseVec)) == '0));

  // R2: a written zero keeps a set bit set
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    strobe.evtClr |=> ((evtReg & $past(evtReg & ~busWdata)) == $past(evtReg & ~busWdata)));

  // R4: unused positions never hold a one
  a_r4_unused_zero: assert property (@(posedge clk) disable iff (rst)
    ((evtReg & ~IMPL_MASK) == '0) && ((enableReg & ~IMPL_MASK) == '0));

  // R5: with nothing enabled and pending, every line is low next cycle
  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    ((evtReg & enableReg) == '0) |=> (!irqTx && !irqRx && !irqErr));

  // R8: any enabled error bit raises the error line next cycle
  a_r8_err_raise: assert property (@(posedge clk) disable iff (rst)
    (|(evtReg & enableReg & groupSel(2))) |=> irqErr);

endmodule

// File: rtl/irq_event_group.sv
module irq_event_group
  import irq_event_group_pkg::*;
#(
  parameter int THR_W = 8,
  parameter int TMO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]   busRdata,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irqTx,
  output logic               irqRx,
  output logic               irqErr
);

  ievtStrobe_t      strobe;
  logic [REG_W-1:0] evtReg;
  logic [REG_W-1:0] enableReg;

  irq_event_group_ctrl #(
    .THR_W(THR_W),
    .TMO_W(TMO_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .cfgWdata  (busWdata[TMO_W-1:0]),
    .framePulse({evtPulse[BIT_RX_FRM], evtPulse[BIT_TX_FRM]}),
    .evtReg    (evtReg),
    .enableReg (enableReg),
    .strobe    (strobe),
    .busRdata  (busRdata)
  );

  irq_event_group_dp i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .busWdata (busWdata),
    .evtPulse (evtPulse),
    .evtReg   (evtReg),
    .enableReg(enableReg),
    .irqTx    (irqTx),
    .irqRx    (irqRx),
    .irqErr   (irqErr)
  );

endmodule

// File: tb/test_irq_event_group.sv
`timescale 1ns/1ps
module test_irq_event_group;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [20:0] evtPulse = '0;
  logic        irqTx, irqRx, irqErr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_event_group i_irq_event_group (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse),
    .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr)
  );

  // ---------------- cycle model built from the requirements ----------------
  localparam logic [31:0] IMPL = 32'h001F_FFFF;
  localparam logic [31:0] TXG  = 32'h0000_0003;
  localparam logic [31:0] RXG  = 32'h0000_000C;
  localparam logic [31:0] ERRG = 32'h001F_FFF0;

  logic [31:0] mEvt, mEn;
  int mThr [2];
  int mTmo [2];
  int mCnt [2];
  int mWait [2];
  bit mHeld [2];
  bit mIrq [3];

  always @(posedge clk) begin
    if (rst) begin
      mEvt = '0; mEn = '0;
      for (int d = 0; d < 2; d++) begin
        mThr[d] = 0; mTmo[d] = 0; mCnt[d] = 0; mWait[d] = 0; mHeld[d] = 0;
      end
      for (int g = 0; g < 3; g++) mIrq[g] = 0;
    end else begin
      bit gt [2];
      logic [31:0] clr;
      for (int d = 0; d < 2; d++) gt[d] = (mThr[d] <= 1) || mHeld[d];
      mIrq[0] = ((mEvt & mEn & TXG) != 0) && gt[0];
      mIrq[1] = ((mEvt & mEn & RXG) != 0) && gt[1];
      mIrq[2] = ((mEvt & mEn & ERRG) != 0);
      for (int d = 0; d < 2; d++) begin
        bit frame, pend;
        int nw;
        frame = evtPulse[2*d+1];
        pend  = ((mEvt >> (2*d)) & 32'd3) != 0;
        if (mThr[d] <= 1) begin
          mCnt[d] = 0; mWait[d] = 0; mHeld[d] = 0;
        end else if ((frame && mCnt[d] + 1 >= mThr[d]) ||
                     (mCnt[d] != 0 && mTmo[d] != 0 && mWait[d] + 1 >= mTmo[d])) begin
          mCnt[d] = 0; mWait[d] = 0; mHeld[d] = 1;
        end else begin
          nw = (mCnt[d] != 0) ? mWait[d] + 1 : 0;
          if (frame) mCnt[d] = mCnt[d] + 1;
          mWait[d] = nw;
          if (!pend) mHeld[d] = 0;
        end
      end
      clr = (busWe && busAddr == 3'd0) ? busWdata : 32'd0;
      mEvt = ((mEvt & ~clr) | {11'd0, evtPulse}) & IMPL;
      if (busWe) begin
        case (busAddr)
          3'd1: mEn = busWdata & IMPL;
          3'd2: mThr[0] = int'(busWdata[7:0]);
          3'd3: mTmo[0] = int'(busWdata[15:0]);
          3'd4: mThr[1] = int'(busWdata[7:0]);
          3'd5: mTmo[1] = int'(busWdata[15:0]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mEvt;
      3'd1: return mEn;
      3'd2: return 32'(mThr[0]);
      3'd3: return 32'(mTmo[0]);
      3'd4: return 32'(mThr[1]);
      3'd5: return 32'(mTmo[1]);
      default: return 32'd0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // advance one cycle and compare all outputs with the model
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R6 model irqTx",  {31'd0, irqTx},  {31'd0, mIrq[0]});
    chk("R7 model irqRx",  {31'd0, irqRx},  {31'd0, mIrq[1]});
    chk("R8 model irqErr", {31'd0, irqErr}, {31'd0, mIrq[2]});
    chk("R1 model read",   busRdata, expRead(busAddr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [2:0] keep;
    keep = busAddr;
    busWe = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWe = 1'b0; busAddr = keep; busWdata = '0;
  endtask

  task automatic pulse(input logic [20:0] p);
    evtPulse = p;
    tick();
    evtPulse = '0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R12: lines low and registers zero after reset
    chk("R12 reset irqTx", {31'd0, irqTx}, 32'd0);
    chk("R12 reset irqErr", {31'd0, irqErr}, 32'd0);
    chk("R12 reset event", busRdata, 32'd0);

    // R4: unused enable bits ignore writes
    wr(3'd1, 32'hFFFF_FFFF);
    busAddr = 3'd1;
    tick();
    chk("R4 enable read", busRdata, 32'h001F_FFFF);
    busAddr = 3'd0;
    wr(3'd0, 32'hFFE0_0000);
    chk("R4 event unused", busRdata, 32'd0);

    // R1, R8, R12: error pulse latches and raises the line two edges later
    pulse(21'h200);
    chk("R1 event bit9", busRdata, 32'h200);
    chk("R12 irqErr one edge", {31'd0, irqErr}, 32'd0);
    tick();
    chk("R8 irqErr set", {31'd0, irqErr}, 32'd1);

    // R2: zero write keeps, one write clears
    wr(3'd0, 32'd0);
    chk("R2 zero write keeps", busRdata, 32'h200);
    wr(3'd0, 32'h200);
    chk("R2 one write clears", busRdata, 32'd0);
    tick();
    chk("R8 irqErr negates", {31'd0, irqErr}, 32'd0);

    // R3: pulse beats same-cycle clear
    evtPulse = 21'h20;
    wr(3'd0, 32'h20);
    evtPulse = '0;
    chk("R3 pulse wins", busRdata, 32'h20);
    wr(3'd0, 32'h20);

    // R5: disabled bit stays quiet
    wr(3'd1, 32'h001F_FFBF);
    pulse(21'h40);
    tick();
    tick();
    chk("R5 masked irqErr", {31'd0, irqErr}, 32'd0);
    chk("R5 bit still pending", busRdata, 32'h40);
    wr(3'd0, 32'h40);
    wr(3'd1, 32'hFFFF_FFFF);

    // R6: transmit line held until both bits cleared (threshold 0 = bypass)
    pulse(21'h3);
    tick();
    chk("R6 irqTx set", {31'd0, irqTx}, 32'd1);
    wr(3'd0, 32'h1);
    tick();
    chk("R6 held with bit1 set", {31'd0, irqTx}, 32'd1);
    wr(3'd0, 32'h2);
    tick();
    chk("R6 irqTx cleared", {31'd0, irqTx}, 32'd0);

    // R9, R7: receive threshold 3, no timeout
    wr(3'd4, 32'd3);
    wr(3'd5, 32'd0);
    pulse(21'h8);
    pulse(21'h8);
    tick();
    tick();
    chk("R9 below threshold", {31'd0, irqRx}, 32'd0);
    pulse(21'h8);
    tick();
    chk("R9 threshold reached", {31'd0, irqRx}, 32'd1);
    wr(3'd0, 32'h8);
    tick();
    chk("R7 irqRx cleared", {31'd0, irqRx}, 32'd0);
    // R11: count restarted after release
    pulse(21'h8);
    pulse(21'h8);
    tick();
    tick();
    chk("R11 counter restarted", {31'd0, irqRx}, 32'd0);
    pulse(21'h8);
    tick();
    chk("R9 third frame again", {31'd0, irqRx}, 32'd1);
    wr(3'd0, 32'h8);
    tick();

    // R10: timeout 10 with threshold 5
    wr(3'd4, 32'd5);
    wr(3'd5, 32'd10);
    pulse(21'h8);
    repeat (10) tick();
    chk("R10 before timeout", {31'd0, irqRx}, 32'd0);
    tick();
    chk("R10 timeout release", {31'd0, irqRx}, 32'd1);
    wr(3'd0, 32'h8);
    tick();

    // R11: threshold 1 behaves as bypass
    wr(3'd4, 32'd1);
    pulse(21'h8);
    tick();
    chk("R11 threshold one bypass", {31'd0, irqRx}, 32'd1);
    wr(3'd0, 32'h8);
    tick();

    // random phase, compared every cycle in tick()
    for (int n = 0; n < 4000; n++) begin
      logic [20:0] p;
      p = '0;
      for (int b = 0; b < 21; b++) p[b] = (($urandom % 12) == 0);
      evtPulse = p;
      busAddr = 3'($urandom % 8);
      if (($urandom % 6) == 0) begin
        busWe = 1'b1;
        case (busAddr)
          3'd1:       busWdata = $urandom | $urandom;
          3'd2, 3'd4: busWdata = $urandom % 7;
          3'd3, 3'd5: busWdata = $urandom % 20;
          default:    busWdata = $urandom;
        endcase
      end else begin
        busWe = 1'b0;
        busWdata = '0;
      end
      tick();
    end
    busWe = 1'b0;
    evtPulse = '0;
    rst = 1'b1;
    tick();
    chk("R12 reset clears lines", {29'd0, irqTx, irqRx, irqErr}, 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule